// File: doc/BRIEF.md
# Descriptor Cache Flush Sequencer with Address Blocking

This block executes flush commands aimed at a descriptor cache, one command at a time. A command names a 40-bit descriptor address and a set of control flags. The sequencer can first free one of four blocking resources, then ask an external agent to drain every packet queued behind the descriptor, then ask the cache to write the line out (and optionally invalidate it). Finally it can park the address in the chosen blocking resource, so that later cache accesses to that address are held off. Each command ends with a one-cycle status pulse that carries the command's tag and a success/error flag.

A whole-cache variant flushes everything and raises a separate whole-cache block. That variant ignores every other field and leaves the four resources untouched. A second command input, the unblock port, releases either one resource or the whole-cache block. The cache asks a combinational probe whether a given address is blocked. The probe answers yes when the whole cache is blocked or when a held resource matches that address.

The cache storage, the packet forwarding engine and the command fetch lie outside the block. They are reached through request/acknowledge pairs and valid/ready inputs.

Top module: `flush_sequencer`

## Requirements
- R1: A flush command takes its address from `cmd_addr_lo` (bits 31:0) and from `cmd_ctrl[7:0]` (bits 39:32). In `cmd_ctrl`, bit 8 is forward, bit 9 is release, bits 11:10 are the resource index (0..3), bit 12 is keep-valid, bit 13 is block-after and bit 14 is whole-cache. Bits 31:15 are ignored.
- R2: With release set, the indexed resource is freed before any other step. If that resource was already free, the command does nothing further and reports `sts_err`=1.
- R3: With block-after set, if the indexed resource is still held after the release step, the command issues no forward and no flush request and reports `sts_err`=1.
- R4: An accepted block-after command stores its address in the indexed resource. From then on `probe_blocked` is 1 for that exact address and 0 for other addresses, until the resource is released.
- R5: With forward set, `fwd_req` is acknowledged before `fl_req` rises. `fwd_req` and `fl_req` are never high together, and each request holds until its acknowledge.
- R6: `fl_inval` is 1 during a single-line flush unless keep-valid is set, in which case it is 0. `fl_addr` equals the command address.
- R7: A whole-cache command ignores all other fields and issues one flush with `fl_all`=1 and `fl_inval`=1. Afterwards `probe_blocked` is 1 for every address until a whole-cache unblock.
- R8: A whole-cache command and the whole-cache unblock leave the four resources unchanged.
- R9: An unblock command with `ublk_whole`=1 clears the whole-cache block; with `ublk_whole`=0 it frees resource `ublk_idx`. If the target is not blocked it reports `sts_err`=1 and changes nothing.
- R10: `cmd_ready` is low from the acceptance of a command until the cycle after its one-cycle `sts_valid` pulse. `sts_tag` echoes the accepted tag. A flush command takes priority over an unblock command in the same cycle.
- R11: After reset the sequencer is idle with `cmd_ready`=1, no request or status outstanding, and no resource or whole-cache block held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Flush command offered |
| cmd_ready | output | 1 | Flush command accepted this cycle when valid |
| cmd_tag | input | TAG_W | Tracking tag of the flush command |
| cmd_addr_lo | input | 32 | Address bits 31:0 |
| cmd_ctrl | input | 32 | Address bits 39:32 and control flags |
| ublk_valid | input | 1 | Unblock command offered |
| ublk_ready | output | 1 | Unblock command accepted this cycle when valid |
| ublk_tag | input | TAG_W | Tracking tag of the unblock command |
| ublk_whole | input | 1 | 1: release the whole-cache block |
| ublk_idx | input | 2 | Resource to release when not whole |
| fwd_req | output | 1 | Forward-all-packets request |
| fwd_addr | output | 40 | Queue descriptor address for forwarding |
| fwd_ack | input | 1 | Forwarding complete |
| fl_req | output | 1 | Cache flush request |
| fl_addr | output | 40 | Line address to flush |
| fl_inval | output | 1 | Invalidate after write-out |
| fl_all | output | 1 | Flush the whole cache |
| fl_ack | input | 1 | Flush complete |
| sts_valid | output | 1 | Status pulse |
| sts_tag | output | TAG_W | Tag of the finished command |
| sts_err | output | 1 | 1: command rejected |
| probe_addr | input | 40 | Address of a cache access |
| probe_blocked | output | 1 | Access must be held off |

## Verification
On every cycle the assertions check the request handshakes: forward and flush requests are never high together, each request holds steady until its acknowledge, status is a single-cycle pulse, the sequencer does not take a second command while busy, and a whole-cache flush ends with the probe reporting blocked. The bench scenarios cover the rest. They show the decision logic of the release and block steps, which resource holds which address, that rejected commands touch neither state nor handshakes, that a whole-cache flush keeps the per-resource blocks, and the unblock error cases.

// File: rtl/fsq_pkg.sv
// Shared constants and types for the flush sequencer.
// Assumes a fixed 40-bit descriptor address split over two command words.
package fsq_pkg;
    localparam int ADDR_W = 40;
    localparam int LO_W   = 32;
    localparam int HI_W   = ADDR_W - LO_W;
    localparam int NRES   = 4;
    localparam int IDX_W  = $clog2(NRES);

    // Flag positions inside the control word
    localparam int B_FWD   = 8;
    localparam int B_REL   = 9;
    localparam int B_IDX   = 10;
    localparam int B_KEEP  = 12;
    localparam int B_BLK   = 13;
    localparam int B_ALL   = 14;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREP,
        S_FWD,
        S_FLUSH,
        S_BLOCK,
        S_STATUS
    } state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              fwd;
        logic              rel;
        logic [IDX_W-1:0]  idx;
        logic              keep;
        logic              blk;
        logic              all;
    } cmd_t;
endpackage

// File: rtl/fsq_cmd_decode.sv
// Splits the two command words into a typed command record.
// Assumes reserved control bits carry no meaning and are dropped.
module fsq_cmd_decode
    import fsq_pkg::*;
(
    input  logic [LO_W-1:0] addr_lo,
    input  logic [31:0]     ctrl,
    output cmd_t            cmd
);
    logic unused_rsvd;

    // Field extraction by fixed bit position
    always_comb begin
        cmd.addr = {ctrl[HI_W-1:0], addr_lo};
        cmd.fwd  = ctrl[B_FWD];
        cmd.rel  = ctrl[B_REL];
        cmd.idx  = ctrl[B_IDX +: IDX_W];
        cmd.keep = ctrl[B_KEEP];
        cmd.blk  = ctrl[B_BLK];
        cmd.all  = ctrl[B_ALL];
    end

    assign unused_rsvd = ^ctrl[31:B_ALL+1];
endmodule

// File: rtl/fsq_block_table.sv
// Holds the indexed address-blocking resources and the whole-cache block,
// and answers the combinational access probe.
// Assumes set and clear never target the same resource in one cycle
// (set wins if they do).
module fsq_block_table #(
    parameter int NRES   = 4,
    parameter int IDX_W  = 2,
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              whole_set,
    input  logic              whole_clr,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic [NRES-1:0]   held,
    output logic              whole_blk,
    output logic              probe_hit
);
    logic [NRES-1:0] match;

    for (genvar i = 0; i < NRES; i++) begin : g_res
        logic [ADDR_W-1:0] addr_q;

        // One resource: occupancy flag and stored address
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held[i] <= 1'b0;
                addr_q  <= '0;
            end else if (set_en && set_idx == IDX_W'(i)) begin
                held[i] <= 1'b1;
                addr_q  <= set_addr;
            end else if (clr_en && clr_idx == IDX_W'(i)) begin
                held[i] <= 1'b0;
            end
        end

        assign match[i] = held[i] && (addr_q == probe_addr);
    end

    // Whole-cache block flag
    always_ff @(posedge clk) begin
        if (!rst_n)         whole_blk <= 1'b0;
        else if (whole_set) whole_blk <= 1'b1;
        else if (whole_clr) whole_blk <= 1'b0;
    end

    assign probe_hit = whole_blk || (|match);
endmodule

// File: rtl/fsq_fsm.sv
// Sequences one command at a time: release, forward, flush, block, status.
// Unblock commands are executed in the accept cycle and then report status.
// Assumes acknowledges arrive only while the matching request is high.
module fsq_fsm
    import fsq_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [TAG_W-1:0]  cmd_tag,
    input  cmd_t              dec,
    input  logic              ublk_valid,
    input  logic [TAG_W-1:0]  ublk_tag,
    input  logic              ublk_whole,
    input  logic [IDX_W-1:0]  ublk_idx,
    input  logic              fwd_ack,
    input  logic              fl_ack,
    input  logic [NRES-1:0]   held,
    input  logic              whole_blk,
    output logic              cmd_ready,
    output logic              ublk_ready,
    output logic              fwd_req,
    output logic              fl_req,
    output logic              fl_inval,
    output logic              fl_all,
    output logic [ADDR_W-1:0] req_addr,
    output logic              sts_valid,
    output logic [TAG_W-1:0]  sts_tag,
    output logic              sts_err,
    output logic              set_en,
    output logic [IDX_W-1:0]  set_idx,
    output logic [ADDR_W-1:0] set_addr,
    output logic              clr_en,
    output logic [IDX_W-1:0]  clr_idx,
    output logic              whole_set,
    output logic              whole_clr
);
    state_t           state_q, state_d;
    cmd_t             cur_q;
    logic [TAG_W-1:0] tag_q;
    logic             err_q, err_d;
    logic             cmd_acc, ublk_acc;
    logic             rel_bad, blk_bad, held_sel, held_after;

    assign cmd_ready  = (state_q == S_IDLE);
    assign ublk_ready = (state_q == S_IDLE) && !cmd_valid;
    assign cmd_acc    = cmd_valid && cmd_ready;
    assign ublk_acc   = ublk_valid && ublk_ready;

    // Release and block checks of the current command
    assign held_sel   = held[cur_q.idx];
    assign held_after = cur_q.rel ? 1'b0 : held_sel;
    assign rel_bad    = cur_q.rel && !held_sel;
    assign blk_bad    = cur_q.blk && held_after;

    // Handshake and status outputs decoded from state
    assign fwd_req   = (state_q == S_FWD);
    assign fl_req    = (state_q == S_FLUSH);
    assign fl_all    = cur_q.all;
    assign fl_inval  = cur_q.all || !cur_q.keep;
    assign req_addr  = cur_q.all ? '0 : cur_q.addr;
    assign sts_valid = (state_q == S_STATUS);
    assign sts_tag   = tag_q;
    assign sts_err   = err_q;

    // Strobes into the blocking table
    always_comb begin
        set_en    = (state_q == S_BLOCK) && !cur_q.all;
        set_idx   = cur_q.idx;
        set_addr  = cur_q.addr;
        whole_set = (state_q == S_BLOCK) && cur_q.all;
        whole_clr = ublk_acc && ublk_whole && whole_blk;
        clr_en    = 1'b0;
        clr_idx   = cur_q.idx;
        if (state_q == S_PREP) begin
            clr_en = cur_q.rel && held_sel;
        end else if (ublk_acc && !ublk_whole) begin
            clr_en  = held[ublk_idx];
            clr_idx = ublk_idx;
        end
    end

    // Next-state and error decision
    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_acc) begin
                    err_d   = 1'b0;
                    state_d = dec.all ? S_FLUSH : S_PREP;
                end else if (ublk_acc) begin
                    err_d   = ublk_whole ? !whole_blk : !held[ublk_idx];
                    state_d = S_STATUS;
                end
            end
            S_PREP: begin
                if (rel_bad || blk_bad) begin
                    err_d   = 1'b1;
                    state_d = S_STATUS;
                end else begin
                    state_d = cur_q.fwd ? S_FWD : S_FLUSH;
                end
            end
            S_FWD:    if (fwd_ack) state_d = S_FLUSH;
            S_FLUSH:  if (fl_ack)  state_d = (cur_q.all || cur_q.blk) ? S_BLOCK : S_STATUS;
            S_BLOCK:  state_d = S_STATUS;
            S_STATUS: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State, error flag and tag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            err_q   <= 1'b0;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            if (cmd_acc)       tag_q <= cmd_tag;
            else if (ublk_acc) tag_q <= ublk_tag;
        end
    end

    // Command capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n)       cur_q <= '0;
        else if (cmd_acc) cur_q <= dec;
    end
endmodule

// File: rtl/flush_sequencer.sv
// Top of the flush sequencer: decodes commands, runs the sequencing FSM and
// keeps the blocking table that answers the cache's access probe.
// Assumes one flush or unblock command in flight at any time.
module flush_sequencer
    import fsq_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [TAG_W-1:0]  cmd_tag,
    input  logic [LO_W-1:0]   cmd_addr_lo,
    input  logic [31:0]       cmd_ctrl,
    input  logic              ublk_valid,
    output logic              ublk_ready,
    input  logic [TAG_W-1:0]  ublk_tag,
    input  logic              ublk_whole,
    input  logic [IDX_W-1:0]  ublk_idx,
    output logic              fwd_req,
    output logic [ADDR_W-1:0] fwd_addr,
    input  logic              fwd_ack,
    output logic              fl_req,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_inval,
    output logic              fl_all,
    input  logic              fl_ack,
    output logic              sts_valid,
    output logic [TAG_W-1:0]  sts_tag,
    output logic              sts_err,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_blocked
);
    cmd_t              dec;
    logic [NRES-1:0]   held;
    logic              whole_blk;
    logic              set_en, clr_en, whole_set, whole_clr;
    logic [IDX_W-1:0]  set_idx, clr_idx;
    logic [ADDR_W-1:0] set_addr, req_addr;

    fsq_cmd_decode u_dec (
        .addr_lo (cmd_addr_lo),
        .ctrl    (cmd_ctrl),
        .cmd     (dec)
    );

    fsq_fsm #(.TAG_W(TAG_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_tag    (cmd_tag),
        .dec        (dec),
        .ublk_valid (ublk_valid),
        .ublk_tag   (ublk_tag),
        .ublk_whole (ublk_whole),
        .ublk_idx   (ublk_idx),
        .fwd_ack    (fwd_ack),
        .fl_ack     (fl_ack),
        .held       (held),
        .whole_blk  (whole_blk),
        .cmd_ready  (cmd_ready),
        .ublk_ready (ublk_ready),
        .fwd_req    (fwd_req),
        .fl_req     (fl_req),
        .fl_inval   (fl_inval),
        .fl_all     (fl_all),
        .req_addr   (req_addr),
        .sts_valid  (sts_valid),
        .sts_tag    (sts_tag),
        .sts_err    (sts_err),
        .set_en     (set_en),
        .set_idx    (set_idx),
        .set_addr   (set_addr),
        .clr_en     (clr_en),
        .clr_idx    (clr_idx),
        .whole_set  (whole_set),
        .whole_clr  (whole_clr)
    );

    fsq_block_table #(.NRES(NRES), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (set_en),
        .set_idx    (set_idx),
        .set_addr   (set_addr),
        .clr_en     (clr_en),
        .clr_idx    (clr_idx),
        .whole_set  (whole_set),
        .whole_clr  (whole_clr),
        .probe_addr (probe_addr),
        .held       (held),
        .whole_blk  (whole_blk),
        .probe_hit  (probe_blocked)
    );

    assign fwd_addr = req_addr;
    assign fl_addr  = req_addr;
endmodule

// File: rtl/fsq_checker.sv
// Protocol properties of the flush sequencer, bound to its top module.
module fsq_checker #(
    parameter int ADDR_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              fwd_req,
    input logic              fwd_ack,
    input logic              fl_req,
    input logic              fl_ack,
    input logic              fl_all,
    input logic [ADDR_W-1:0] fl_addr,
    input logic              sts_valid,
    input logic              probe_blocked
);
    // R5
    fwd_fl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_req && fl_req));

    // R5
    fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_req && !fwd_ack) |=> fwd_req);

    // R5
    fl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr)));

    // R5
    fwd_then_fl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_req && fwd_ack) |=> fl_req);

    // R10
    sts_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid |=> !sts_valid);

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R10
    sts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid |-> !cmd_ready);

    // R7
    whole_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_ack && fl_all) |=> ##1 probe_blocked);
endmodule

bind flush_sequencer fsq_checker #(.ADDR_W(fsq_pkg::ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .fwd_req       (fwd_req),
    .fwd_ack       (fwd_ack),
    .fl_req        (fl_req),
    .fl_ack        (fl_ack),
    .fl_all        (fl_all),
    .fl_addr       (fl_addr),
    .sts_valid     (sts_valid),
    .probe_blocked (probe_blocked)
);

// File: tb/sim_flush_sequencer.sv
module sim_flush_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_tag = '0;
    logic [31:0] cmd_addr_lo = '0;
    logic [31:0] cmd_ctrl = '0;
    logic        ublk_valid = 1'b0;
    logic        ublk_ready;
    logic [7:0]  ublk_tag = '0;
    logic        ublk_whole = 1'b0;
    logic [1:0]  ublk_idx = '0;
    logic        fwd_req;
    logic [39:0] fwd_addr;
    logic        fwd_ack = 1'b0;
    logic        fl_req;
    logic [39:0] fl_addr;
    logic        fl_inval;
    logic        fl_all;
    logic        fl_ack = 1'b0;
    logic        sts_valid;
    logic [7:0]  sts_tag;
    logic        sts_err;
    logic [39:0] probe_addr = '0;
    logic        probe_blocked;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Responder bookkeeping
    int          fwd_seen, fl_seen, ev_cnt, fwd_stamp, fl_stamp;
    logic [39:0] got_addr;
    logic        got_inval, got_all;

    flush_sequencer #(.TAG_W(TAG_W)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Acknowledge model: each request is answered after two waiting cycles
    initial begin
        int fc = 0, lc = 0;
        fwd_seen = 0; fl_seen = 0; ev_cnt = 0; fwd_stamp = 0; fl_stamp = 0;
        forever begin
            @(negedge clk);
            if (fwd_ack) fwd_ack = 1'b0;
            else if (fwd_req) begin
                fc++;
                if (fc == 2) begin
                    fc = 0; fwd_ack = 1'b1; fwd_seen++; fwd_stamp = ev_cnt++;
                end
            end
            if (fl_ack) fl_ack = 1'b0;
            else if (fl_req) begin
                lc++;
                if (lc == 2) begin
                    lc = 0; fl_ack = 1'b1; fl_seen++; fl_stamp = ev_cnt++;
                    got_addr = fl_addr; got_inval = fl_inval; got_all = fl_all;
                end
            end
        end
    end

    typedef struct packed {
        logic        kind;    // 0 flush command, 1 unblock
        logic        uwhole;
        logic [1:0]  uidx;
        logic [31:0] ctrl;
        logic [31:0] lo;
        logic        e_err;
        logic        e_fwd;
        logic        e_fl;
        logic        e_inv;
        logic        e_all;
        logic [39:0] probe;
        logic        e_blk;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R1 R6: plain flush, idx 0, invalidates
        '{1'b0,1'b0,2'd0,32'h0000_0012,32'h0000_1000,1'b0,1'b0,1'b1,1'b1,1'b0,40'h12_0000_1000,1'b0},
        // R6: keep-valid flush
        '{1'b0,1'b0,2'd0,32'h0000_1034,32'h0000_2000,1'b0,1'b0,1'b1,1'b0,1'b0,40'h34_0000_2000,1'b0},
        // R4 R5: forward + block on idx 1
        '{1'b0,1'b0,2'd0,32'h0000_2556,32'h0000_3000,1'b0,1'b1,1'b1,1'b1,1'b0,40'h56_0000_3000,1'b1},
        // R3: block on held idx 1 rejected, old block kept
        '{1'b0,1'b0,2'd0,32'h0000_2478,32'h0000_4000,1'b1,1'b0,1'b0,1'b0,1'b0,40'h56_0000_3000,1'b1},
        // R2 R4: release + reuse idx 1 with forward
        '{1'b0,1'b0,2'd0,32'h0000_2778,32'h0000_4000,1'b0,1'b1,1'b1,1'b1,1'b0,40'h78_0000_4000,1'b1},
        // R2: release of free idx 2 rejected; old addr of idx 1 freed
        '{1'b0,1'b0,2'd0,32'h0000_0A9A,32'h0000_5000,1'b1,1'b0,1'b0,1'b0,1'b0,40'h56_0000_3000,1'b0},
        // R9: unblock idx 1
        '{1'b1,1'b0,2'd1,32'h0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,40'h78_0000_4000,1'b0},
        // R9: unblock free idx 1 -> error
        '{1'b1,1'b0,2'd1,32'h0,32'h0,1'b1,1'b0,1'b0,1'b0,1'b0,40'h78_0000_4000,1'b0},
        // R4 R6: keep-valid + block on idx 0
        '{1'b0,1'b0,2'd0,32'h0000_30AB,32'h0000_6000,1'b0,1'b0,1'b1,1'b0,1'b0,40'hAB_0000_6000,1'b1},
        // R7: whole flush with junk fields (release of free idx 3 ignored)
        '{1'b0,1'b0,2'd0,32'h0000_6FCD,32'h0000_7000,1'b0,1'b0,1'b1,1'b1,1'b1,40'h00_0000_0000,1'b1},
        // R8 R9: whole unblock; idx 0 block survives
        '{1'b1,1'b1,2'd0,32'h0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,40'hAB_0000_6000,1'b1},
        // R9: whole unblock when not blocked -> error
        '{1'b1,1'b1,2'd0,32'h0,32'h0,1'b1,1'b0,1'b0,1'b0,1'b0,40'h00_0000_0000,1'b0},
        // R9: unblock idx 0
        '{1'b1,1'b0,2'd0,32'h0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,40'hAB_0000_6000,1'b0}
    };

    task automatic wait_status(output bit ok);
        ok = 1'b0;
        for (int w = 0; w < 200; w++) begin
            @(negedge clk);
            if (sts_valid) begin ok = 1'b1; break; end
        end
    endtask

    initial begin
        bit got;
        // R11: reset state
        repeat (3) @(negedge clk);
        probe_addr = 40'h12_0000_1000;
        chk(cmd_ready == 1'b1, "R11 cmd_ready in reset", cmd_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sts_valid && !fwd_req && !fl_req, "R11 idle outputs",
            {sts_valid, fwd_req, fl_req}, 0);
        chk(probe_blocked == 1'b0, "R11 nothing blocked", probe_blocked, 0);

        for (int v = 0; v < NV; v++) begin
            vec_t t = VECS[v];
            fwd_seen = 0; fl_seen = 0;
            if (t.kind == 1'b0) begin
                cmd_valid = 1'b1; cmd_tag = 8'(v + 8'h40);
                cmd_ctrl = t.ctrl; cmd_addr_lo = t.lo;
                @(negedge clk);
                cmd_valid = 1'b0;
                chk(cmd_ready == 1'b0, $sformatf("R10 busy after accept v%0d", v), cmd_ready, 0);
            end else begin
                ublk_valid = 1'b1; ublk_tag = 8'(v + 8'h40);
                ublk_whole = t.uwhole; ublk_idx = t.uidx;
                @(negedge clk);
                ublk_valid = 1'b0;
            end
            if (!sts_valid) wait_status(got); else got = 1'b1;
            chk(got, $sformatf("R10 status seen v%0d", v), got, 1);
            chk(sts_tag == 8'(v + 8'h40), $sformatf("R10 tag v%0d", v), sts_tag, v + 8'h40);
            chk(sts_err == t.e_err, $sformatf("R2 R3 R9 status error v%0d", v), sts_err, t.e_err);
            chk(fwd_seen == int'(t.e_fwd), $sformatf("R5 forward count v%0d", v), fwd_seen, t.e_fwd);
            chk(fl_seen == int'(t.e_fl), $sformatf("R3 flush count v%0d", v), fl_seen, t.e_fl);
            if (t.e_fl) begin
                chk(got_inval == t.e_inv, $sformatf("R6 invalidate v%0d", v), got_inval, t.e_inv);
                chk(got_all == t.e_all, $sformatf("R7 whole flag v%0d", v), got_all, t.e_all);
                if (!t.e_all)
                    chk(got_addr == {t.ctrl[7:0], t.lo}, $sformatf("R1 flush addr v%0d", v),
                        got_addr, {t.ctrl[7:0], t.lo});
            end
            if (t.e_fwd && t.e_fl)
                chk(fwd_stamp < fl_stamp, $sformatf("R5 order v%0d", v), fwd_stamp, fl_stamp);
            @(negedge clk);
            probe_addr = t.probe;
            #1;
            chk(probe_blocked == t.e_blk, $sformatf("R4 R7 R8 probe v%0d", v), probe_blocked, t.e_blk);
            chk(cmd_ready == 1'b1, $sformatf("R10 ready after status v%0d", v), cmd_ready, 1);
        end

        // R4: neighbouring address not blocked by a held resource
        cmd_valid = 1'b1; cmd_tag = 8'h77; cmd_ctrl = 32'h0000_28EE; cmd_addr_lo = 32'h0000_9000;
        @(negedge clk); cmd_valid = 1'b0;
        wait_status(got);
        @(negedge clk);
        probe_addr = 40'hEE_0000_9000; #1;
        chk(probe_blocked == 1'b1, "R4 idx2 address blocked", probe_blocked, 1);
        probe_addr = 40'hEE_0000_9001; #1;
        chk(probe_blocked == 1'b0, "R4 other address free", probe_blocked, 0);

        // R10: flush command wins over a simultaneous unblock
        cmd_valid = 1'b1; cmd_tag = 8'h55; cmd_ctrl = 32'h0000_0001; cmd_addr_lo = 32'h0;
        ublk_valid = 1'b1; ublk_tag = 8'h66; ublk_whole = 1'b0; ublk_idx = 2'd2;
        #1;
        chk(ublk_ready == 1'b0, "R10 unblock held off", ublk_ready, 0);
        @(negedge clk); cmd_valid = 1'b0;
        wait_status(got);
        chk(sts_tag == 8'h55, "R10 flush served first", sts_tag, 8'h55);
        wait_status(got);
        chk(sts_tag == 8'h66 && !sts_err, "R9 queued unblock served", {sts_tag, sts_err}, {8'h66, 1'b0});
        ublk_valid = 1'b0;
        @(negedge clk);
        probe_addr = 40'hEE_0000_9000; #1;
        chk(probe_blocked == 1'b0, "R9 idx2 released", probe_blocked, 0);

        // R11: reset clears a held resource
        cmd_valid = 1'b1; cmd_tag = 8'h78; cmd_ctrl = 32'h0000_2CEE; cmd_addr_lo = 32'h0000_9000;
        @(negedge clk); cmd_valid = 1'b0;
        wait_status(got);
        @(negedge clk); #1;
        chk(probe_blocked == 1'b1, "R4 idx3 held before reset", probe_blocked, 1);
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk(probe_blocked == 1'b0, "R11 reset frees resources", probe_blocked, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule